// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This unit produces the bit timing for a CAN receiver. A programmable prescaler divides the module clock into time quanta. A segment sequencer then walks each nominal bit through four segments: a one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. At the point where phase segment 1 ends, the unit samples the receive line. It raises a one-cycle sample strobe there, and another one-cycle strobe when a bit ends.

The receive line is observed once per quantum. A recessive-to-dominant transition (1 to 0) on the receive line is handled in one of two ways:

- While the bus is flagged idle, the transition restarts the bit (hard synchronization).
- Otherwise, the transition moves the sample point, by lengthening phase segment 1 or shortening phase segment 2. The move never exceeds the jump width.

The configuration inputs are registered inside the unit. A configuration that cannot be timed raises an error flag, and the timing logic stays in reset for as long as that configuration is applied.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_en` pulses for one cycle every `cfg_div`+1 module clocks. The legal `cfg_div` range is 1..127 with `cfg_wide`=0 and 1..255 with `cfg_wide`=1. Any other value sets `cfg_err`.
- R2: Without synchronization, a bit lasts 1 + P + A + B quanta and ends with a one-cycle `bit_stb`. Here P = `cfg_prop`+1 and A = `cfg_ph1`+1 are the propagation and phase 1 lengths, and B is the phase 2 length.
- R3: The phase 2 length B is the larger of A and `cfg_ipt` (the processing time, 0..2 quanta). A `cfg_ipt` value of 3 sets `cfg_err`.
- R4: `sample_stb` pulses for one cycle, one clock after the `tq_en` that ends phase segment 1. In that same cycle, `rx_bit` takes the value `rxd` had at that `tq_en`. At all other times `rx_bit` holds its value.
- R5: A total of 1+P+A+B outside 8..25 quanta sets `cfg_err`.
- R6: A jump width S = `cfg_sjw`+1 greater than A sets `cfg_err`.
- R7: While `cfg_err` is high, `tq_en`, `sample_stb` and `bit_stb` stay low and `rx_bit` returns to 1. When a legal configuration is applied again, timing restarts from the start of a bit.
- R8: When `bus_idle`=1, a 1-to-0 change of `rxd` between consecutive quantum samples makes the quantum just ended the sync segment. The next quantum is then the first quantum of the propagation segment.
- R9: When `bus_idle`=0, an edge seen in the propagation segment or in phase segment 1 lengthens phase segment 1 by min(e, S). Here e is the number of quanta from the end of the sync segment up to and including the quantum of the edge.
- R10: When `bus_idle`=0, an edge seen in phase segment 2 before its last quantum shortens phase segment 2 by min(r, S). Here r is the number of quanta left after the quantum of the edge. When the shortening equals r, the bit ends at once.
- R11: Only one adjustment is made per bit. An edge seen in the sync segment causes no adjustment.
- R12: After reset, all configuration fields read as zero, so `cfg_err`=1. In the same state `tq_en`, `sample_stb` and `bit_stb` are 0 and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | DIV_W (8) | Prescaler ratio minus one |
| cfg_wide | input | 1 | Prescaler mode: 1 raises the ceiling to 256 |
| cfg_prop | input | SEG_W (3) | Propagation length minus one |
| cfg_ph1 | input | SEG_W (3) | Phase segment 1 length minus one |
| cfg_ipt | input | IPT_W (2) | Processing time in quanta |
| cfg_sjw | input | SJW_W (2) | Jump width minus one |
| bus_idle | input | 1 | Bus idle: selects hard synchronization |
| rxd | input | 1 | Receive line (1 recessive, 0 dominant) |
| tq_en | output | 1 | Time-quantum enable |
| sample_stb | output | 1 | Sample-point strobe |
| bit_stb | output | 1 | Bit-boundary strobe |
| rx_bit | output | 1 | Last sampled bus value |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The bench builds the unit with its default parameters: an 8-bit ratio field, 3-bit segment fields and a 2-bit jump width. With these values it can reach both prescaler ceilings, 128 and 256, and the first value past each ceiling. It can also reach both ends of the 8 to 25 quantum window and the first totals outside it, the 1-to-4 jump width against short phase segments, and a processing time larger than phase segment 1. Random receive-line traffic places edges in every segment, with the idle flag both set and cleared. The behavioural model sees the same traffic, so every lengthening, shortening and hard restart is compared on every clock.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PROP = 2'd1,
      SEG_PH1  = 2'd2,
      SEG_PH2  = 2'd3
   } bt_seg_e;

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
   parameter int DIV_W   = 8,
   parameter int SEG_W   = 3,
   parameter int SJW_W   = 2,
   parameter int IPT_W   = 2,
   parameter int IPT_MAX = 2,
   parameter int MIN_TQ  = 8,
   parameter int MAX_TQ  = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] in_div,
   input  logic             in_wide,
   input  logic [SEG_W-1:0] in_prop,
   input  logic [SEG_W-1:0] in_ph1,
   input  logic [IPT_W-1:0] in_ipt,
   input  logic [SJW_W-1:0] in_sjw,
   output logic [DIV_W-1:0] div_q,
   output logic [SEG_W:0]   prop_len,
   output logic [SEG_W:0]   ph1_len,
   output logic [SEG_W:0]   ph2_len,
   output logic [SEG_W:0]   sjw_len,
   output logic             bad
);
   localparam int LEN_W = SEG_W + 1;
   localparam int TOT_W = $clog2(3 * (2 ** SEG_W) + 2) + 1;
   localparam logic [DIV_W-1:0] LIM_NARROW = DIV_W'((2 ** (DIV_W - 1)) - 1);
   localparam logic [DIV_W-1:0] LIM_WIDE   = {DIV_W{1'b1}};
   localparam logic [LEN_W-1:0] LEN_ONE    = LEN_W'(1);

   logic             wide_q;
   logic [SEG_W-1:0] prop_q, ph1_q;
   logic [IPT_W-1:0] ipt_q;
   logic [SJW_W-1:0] sjw_q;
   logic [LEN_W-1:0] ipt_len;
   logic [TOT_W-1:0] total;
   logic [DIV_W-1:0] div_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         wide_q <= 1'b0;
         prop_q <= '0;
         ph1_q  <= '0;
         ipt_q  <= '0;
         sjw_q  <= '0;
      end else begin
         div_q  <= in_div;
         wide_q <= in_wide;
         prop_q <= in_prop;
         ph1_q  <= in_ph1;
         ipt_q  <= in_ipt;
         sjw_q  <= in_sjw;
      end
   end

   always_comb begin
      prop_len = LEN_W'(prop_q) + LEN_ONE;
      ph1_len  = LEN_W'(ph1_q) + LEN_ONE;
      sjw_len  = LEN_W'(sjw_q) + LEN_ONE;
      ipt_len  = LEN_W'(ipt_q);
      ph2_len  = (ph1_len >= ipt_len) ? ph1_len : ipt_len;
      total    = TOT_W'(1) + TOT_W'(prop_len) + TOT_W'(ph1_len) + TOT_W'(ph2_len);
      div_lim  = wide_q ? LIM_WIDE : LIM_NARROW;
      bad      = (div_q == '0) || (div_q > div_lim)
              || (ipt_q > IPT_W'(IPT_MAX))
              || (total < TOT_W'(MIN_TQ)) || (total > TOT_W'(MAX_TQ))
              || (sjw_len > ph1_len);
   end

endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] pcnt;

   assign tick = !hold && (pcnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt <= '0;
      else if (hold || tick)
         pcnt <= '0;
      else
         pcnt <= pcnt + DIV_W'(1);
   end

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
   import can_bt_pkg::*;
#(
   parameter int SEG_W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic         tick,
   input  logic         rxd,
   input  logic         bus_idle,
   input  logic [SEG_W:0] prop_len,
   input  logic [SEG_W:0] ph1_len,
   input  logic [SEG_W:0] ph2_len,
   input  logic [SEG_W:0] sjw_len,
   output logic         sample_stb,
   output logic         bit_stb,
   output logic         rx_bit
);
   localparam int CNT_W = SEG_W + 2;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   bt_seg_e          seg;
   logic [CNT_W-1:0] cnt, ext;
   logic             adj_done, rx_prev;
   logic             edge_det, do_adj, hard;
   logic [CNT_W-1:0] late_err, late_cap, sjw_c;
   logic [CNT_W-1:0] prop_last, ph1_end, ph2_last, rem, cut;

   always_comb begin
      edge_det  = tick && rx_prev && !rxd;
      hard      = edge_det && bus_idle;
      do_adj    = edge_det && !bus_idle && !adj_done;
      sjw_c     = CNT_W'(sjw_len);
      late_err  = (seg == SEG_PROP) ? cnt + ONE : CNT_W'(prop_len) + cnt + ONE;
      late_cap  = (late_err > sjw_c) ? sjw_c : late_err;
      prop_last = CNT_W'(prop_len) - ONE;
      ph1_end   = CNT_W'(ph1_len) + (do_adj ? late_cap : ext) - ONE;
      ph2_last  = CNT_W'(ph2_len) - ONE;
      rem       = ph2_last - cnt;
      cut       = (rem > sjw_c) ? sjw_c : rem;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg <= SEG_SYNC;   cnt <= '0;   ext <= '0;   adj_done <= 1'b0;
         rx_prev <= 1'b1;   rx_bit <= 1'b1;
         sample_stb <= 1'b0; bit_stb <= 1'b0;
      end else if (hold) begin
         seg <= SEG_SYNC;   cnt <= '0;   ext <= '0;   adj_done <= 1'b0;
         rx_prev <= 1'b1;   rx_bit <= 1'b1;
         sample_stb <= 1'b0; bit_stb <= 1'b0;
      end else begin
         sample_stb <= 1'b0;
         bit_stb    <= 1'b0;
         if (tick) begin
            rx_prev <= rxd;
            if (hard) begin
               seg <= SEG_PROP;  cnt <= '0;  ext <= '0;  adj_done <= 1'b0;
            end else begin
               unique case (seg)
                  SEG_SYNC: begin
                     seg <= SEG_PROP;
                     cnt <= '0;
                  end
                  SEG_PROP: begin
                     if (do_adj) begin
                        ext      <= late_cap;
                        adj_done <= 1'b1;
                     end
                     if (cnt >= prop_last) begin
                        seg <= SEG_PH1;
                        cnt <= '0;
                     end else begin
                        cnt <= cnt + ONE;
                     end
                  end
                  SEG_PH1: begin
                     if (do_adj) begin
                        ext      <= late_cap;
                        adj_done <= 1'b1;
                     end
                     if (cnt >= ph1_end) begin
                        seg        <= SEG_PH2;
                        cnt        <= '0;
                        ext        <= '0;
                        sample_stb <= 1'b1;
                        rx_bit     <= rxd;
                     end else begin
                        cnt <= cnt + ONE;
                     end
                  end
                  SEG_PH2: begin
                     if (cnt >= ph2_last || (do_adj && cut == rem)) begin
                        seg      <= SEG_SYNC;
                        cnt      <= '0;
                        adj_done <= 1'b0;
                        bit_stb  <= 1'b1;
                     end else if (do_adj) begin
                        cnt      <= cnt + cut + ONE;
                        adj_done <= 1'b1;
                     end else begin
                        cnt <= cnt + ONE;
                     end
                  end
                  default: begin
                     seg <= SEG_SYNC;
                     cnt <= '0;
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
   parameter int DIV_W   = 8,
   parameter int SEG_W   = 3,
   parameter int SJW_W   = 2,
   parameter int IPT_W   = 2,
   parameter int IPT_MAX = 2,
   parameter int MIN_TQ  = 8,
   parameter int MAX_TQ  = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_wide,
   input  logic [SEG_W-1:0] cfg_prop,
   input  logic [SEG_W-1:0] cfg_ph1,
   input  logic [IPT_W-1:0] cfg_ipt,
   input  logic [SJW_W-1:0] cfg_sjw,
   input  logic             bus_idle,
   input  logic             rxd,
   output logic             tq_en,
   output logic             sample_stb,
   output logic             bit_stb,
   output logic             rx_bit,
   output logic             cfg_err
);
   localparam int LEN_W = SEG_W + 1;

   if (DIV_W < 2) begin : g_bad_div
      $error("can_bit_timer: DIV_W must be at least 2");
   end
   if (SJW_W > SEG_W) begin : g_bad_sjw
      $error("can_bit_timer: SJW_W must not exceed SEG_W");
   end
   if (IPT_W > LEN_W) begin : g_bad_ipt
      $error("can_bit_timer: IPT_W must not exceed SEG_W+1");
   end
   if (MIN_TQ > MAX_TQ) begin : g_bad_win
      $error("can_bit_timer: MIN_TQ must not exceed MAX_TQ");
   end

   logic [DIV_W-1:0] div_q;
   logic [LEN_W-1:0] prop_len, ph1_len, ph2_len, sjw_len;

   can_bt_cfg #(
      .DIV_W(DIV_W), .SEG_W(SEG_W), .SJW_W(SJW_W), .IPT_W(IPT_W),
      .IPT_MAX(IPT_MAX), .MIN_TQ(MIN_TQ), .MAX_TQ(MAX_TQ)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .in_div(cfg_div), .in_wide(cfg_wide), .in_prop(cfg_prop),
      .in_ph1(cfg_ph1), .in_ipt(cfg_ipt), .in_sjw(cfg_sjw),
      .div_q(div_q), .prop_len(prop_len), .ph1_len(ph1_len),
      .ph2_len(ph2_len), .sjw_len(sjw_len), .bad(cfg_err)
   );

   can_bt_presc #(.DIV_W(DIV_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .hold(cfg_err), .div(div_q), .tick(tq_en)
   );

   can_bt_seq #(.SEG_W(SEG_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .hold(cfg_err), .tick(tq_en),
      .rxd(rxd), .bus_idle(bus_idle),
      .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw_len(sjw_len),
      .sample_stb(sample_stb), .bit_stb(bit_stb), .rx_bit(rx_bit)
   );

endmodule

// File: rtl/can_bt_chk.sv
module can_bt_chk (
   input logic clk,
   input logic rst_n,
   input logic tq_en,
   input logic sample_stb,
   input logic bit_stb,
   input logic rx_bit,
   input logic cfg_err
);
   a_r1_tq_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tq_en |=> !tq_en);

   a_r4_samp_after_tq: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> $past(tq_en));

   a_r2_bit_after_tq: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> $past(tq_en));

   a_r4_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && bit_stb));

   a_r7_err_no_tq: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !tq_en);

   a_r7_err_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && $past(cfg_err)) |-> (!sample_stb && !bit_stb && rx_bit));

   a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_stb && !$past(cfg_err)) |-> $stable(rx_bit));
endmodule

bind can_bit_timer can_bt_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .sample_stb(sample_stb),
   .bit_stb(bit_stb), .rx_bit(rx_bit), .cfg_err(cfg_err)
);

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
   localparam int WD_CYCLES = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cfg_div = 8'd1;
   logic       cfg_wide = 1'b0;
   logic [2:0] cfg_prop = 3'd3;
   logic [2:0] cfg_ph1 = 3'd2;
   logic [1:0] cfg_ipt = 2'd0;
   logic [1:0] cfg_sjw = 2'd1;
   logic       bus_idle = 1'b0;
   logic       rxd = 1'b1;
   logic       tq_en, sample_stb, bit_stb, rx_bit, cfg_err;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string cur_req = "R12";

   // behavioural reference state
   int m_div = 0, m_wide = 0, m_prop = 0, m_ph1 = 0, m_ipt = 0, m_sjw = 0;
   int m_pc = 0, m_seg = 0, m_cnt = 0, m_ext = 0;
   bit m_adj = 0, m_prev = 1, m_rxb = 1, m_samp = 0, m_bstb = 0;

   always #4 clk = ~clk;

   can_bit_timer u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_wide(cfg_wide),
      .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1), .cfg_ipt(cfg_ipt), .cfg_sjw(cfg_sjw),
      .bus_idle(bus_idle), .rxd(rxd), .tq_en(tq_en), .sample_stb(sample_stb),
      .bit_stb(bit_stb), .rx_bit(rx_bit), .cfg_err(cfg_err)
   );

   function automatic bit ref_bad();
      int a, b, tot, lim;
      a   = m_ph1 + 1;
      b   = (a > m_ipt) ? a : m_ipt;
      tot = 1 + (m_prop + 1) + a + b;
      lim = m_wide ? 255 : 127;
      return (m_div == 0) || (m_div > lim) || (m_ipt > 2) ||
             (tot < 8) || (tot > 25) || ((m_sjw + 1) > a);
   endfunction

   task automatic ref_clear();
      m_pc = 0; m_seg = 0; m_cnt = 0; m_ext = 0; m_adj = 0;
      m_prev = 1; m_rxb = 1; m_samp = 0; m_bstb = 0;
   endtask

   task automatic ref_end_bit();
      m_seg = 0; m_cnt = 0; m_adj = 0; m_bstb = 1;
   endtask

   always @(posedge clk) begin
      int p, a, b, s, late, cap, e1, last2, rem, cut;
      bit tk, ed, adj_now;
      if (!rst_n) begin
         ref_clear();
         m_div = 0; m_wide = 0; m_prop = 0; m_ph1 = 0; m_ipt = 0; m_sjw = 0;
      end else begin
         p = m_prop + 1;
         a = m_ph1 + 1;
         b = (a > m_ipt) ? a : m_ipt;
         s = m_sjw + 1;
         if (ref_bad()) begin
            ref_clear();
         end else begin
            tk = (m_pc >= m_div);
            m_samp = 0;
            m_bstb = 0;
            if (tk) begin
               ed      = m_prev && !rxd;
               m_prev  = rxd;
               adj_now = ed && !m_adj && !bus_idle;
               if (ed && bus_idle) begin
                  m_seg = 1; m_cnt = 0; m_ext = 0; m_adj = 0;
               end else begin
                  case (m_seg)
                     0: begin m_seg = 1; m_cnt = 0; end
                     1: begin
                        late = m_cnt + 1;
                        cap  = (late > s) ? s : late;
                        if (adj_now) begin m_ext = cap; m_adj = 1; end
                        if (m_cnt >= p - 1) begin m_seg = 2; m_cnt = 0; end
                        else m_cnt++;
                     end
                     2: begin
                        late = p + m_cnt + 1;
                        cap  = (late > s) ? s : late;
                        e1   = a + (adj_now ? cap : m_ext) - 1;
                        if (adj_now) begin m_ext = cap; m_adj = 1; end
                        if (m_cnt >= e1) begin
                           m_seg = 3; m_cnt = 0; m_ext = 0; m_samp = 1; m_rxb = rxd;
                        end else m_cnt++;
                     end
                     default: begin
                        last2 = b - 1;
                        if (m_cnt >= last2) ref_end_bit();
                        else if (adj_now) begin
                           rem = last2 - m_cnt;
                           cut = (rem > s) ? s : rem;
                           if (cut == rem) ref_end_bit();
                           else begin m_cnt = m_cnt + cut + 1; m_adj = 1; end
                        end else m_cnt++;
                     end
                  endcase
               end
            end
            m_pc = tk ? 0 : m_pc + 1;
         end
         m_div = cfg_div; m_wide = cfg_wide; m_prop = cfg_prop;
         m_ph1 = cfg_ph1; m_ipt = cfg_ipt; m_sjw = cfg_sjw;
      end
   end

   task automatic cmp(string sig, string rq, int act, int exp);
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s/%s %s: got %0d expected %0d at %0t", cur_req, rq, sig, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      bit eb;
      if (!done) begin
         eb = ref_bad();
         n_vec++;
         cmp("cfg_err", "R5", int'(cfg_err), int'(eb));
         cmp("tq_en", "R1", int'(tq_en), int'(!eb && (m_pc >= m_div)));
         cmp("sample_stb", "R4", int'(sample_stb), int'(m_samp));
         cmp("bit_stb", "R2", int'(bit_stb), int'(m_bstb));
         cmp("rx_bit", "R4", int'(rx_bit), int'(m_rxb));
      end
   end

   task automatic setcfg(int dv, int wd, int pr, int p1, int ip, int sj);
      @(negedge clk);
      cfg_div = 8'd0;
      repeat (2) @(negedge clk);
      cfg_div = 8'(dv); cfg_wide = wd[0]; cfg_prop = 3'(pr);
      cfg_ph1 = 3'(p1); cfg_ipt = 2'(ip); cfg_sjw = 2'(sj);
   endtask

   task automatic traffic(int n, int flip);
      repeat (n) begin
         @(negedge clk);
         if (flip > 0 && $urandom_range(flip - 1) == 0) rxd = ~rxd;
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #(WD_CYCLES * 8);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL %s watchdog: got running expected finished", cur_req);
         summary();
         $finish;
      end
   end

   initial begin
      // R12: reset state, checked by the per-cycle compare
      cur_req = "R12";
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1: minimum ratio, narrow ceiling, wide ceiling, out of range values
      cur_req = "R1";
      setcfg(1, 0, 3, 2, 0, 1);   traffic(600, 0);
      setcfg(127, 0, 3, 2, 0, 1); traffic(4000, 0);
      setcfg(255, 1, 3, 2, 0, 1); traffic(6000, 0);
      setcfg(128, 0, 3, 2, 0, 1); traffic(60, 0);
      setcfg(0, 1, 3, 2, 0, 1);   traffic(60, 0);
      // R2: bit-length window ends, 8 and 25 quanta
      cur_req = "R2";
      setcfg(1, 0, 2, 1, 0, 0);   traffic(800, 20);
      setcfg(2, 0, 7, 7, 2, 3);   traffic(1500, 30);
      // R3: processing time above phase 1 length, then illegal value 3
      cur_req = "R3";
      setcfg(2, 0, 7, 0, 2, 0);   traffic(3000, 12);
      setcfg(2, 0, 7, 3, 3, 0);   traffic(60, 0);
      // R5: totals of 4 and 7 quanta
      cur_req = "R5";
      setcfg(1, 0, 0, 0, 0, 0);   traffic(60, 5);
      setcfg(1, 0, 1, 1, 0, 0);   traffic(60, 5);
      // R6: jump width larger than phase 1, then equal
      cur_req = "R6";
      setcfg(1, 0, 4, 1, 0, 2);   traffic(60, 5);
      setcfg(1, 0, 4, 1, 0, 1);   traffic(1500, 15);
      // R8: hard synchronization with the bus idle
      cur_req = "R8";
      bus_idle = 1'b1;
      setcfg(1, 0, 3, 3, 0, 2);   traffic(3000, 15);
      setcfg(3, 0, 5, 4, 1, 3);   traffic(3000, 40);
      bus_idle = 1'b0;
      // R9: late edges lengthen phase 1, R10: early edges shorten phase 2
      cur_req = "R9";
      setcfg(1, 0, 4, 5, 0, 3);   traffic(4000, 18);
      cur_req = "R10";
      setcfg(1, 0, 2, 7, 0, 3);   traffic(4000, 25);
      setcfg(2, 0, 3, 4, 2, 0);   traffic(4000, 30);
      // R11: dense edges, several per bit
      cur_req = "R11";
      setcfg(1, 0, 3, 3, 1, 1);   traffic(4000, 4);
      // R7: legal run, illegal window, recovery
      cur_req = "R7";
      setcfg(1, 0, 3, 3, 0, 1);   traffic(500, 20);
      cfg_ipt = 2'd3;             traffic(200, 10);
      cfg_ipt = 2'd0;             traffic(800, 20);
      cfg_sjw = 2'd3; cfg_ph1 = 3'd1; traffic(100, 10);
      cfg_sjw = 2'd1; cfg_ph1 = 3'd3; traffic(800, 20);
      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule